// File: doc/BRIEF.md
# Output Drive Gating Controller

This block sits between the serial command latch of an eight-channel power switch and its gate drivers. It holds the most recent command byte and combines it with two direct pulse-width inputs and several protection flags to produce one gate-enable signal per channel. Channels 5 and 6 (vector indices 4 and 5) can each be switched either by their command bit or by a dedicated direct input, so a fast PWM source can drive them without serial traffic.

A global enable and a supply overvoltage flag switch off every channel. The command byte is kept through either condition, so the channels return to their commanded state when the condition clears. An overtemperature flag for one channel switches off only that channel, which turns on again on its own once the flag drops. Overvoltage and overtemperature flags come from analog sensing, so each passes through a two-stage synchronizer before it takes effect. Logic undervoltage acts as a reset. It switches off every channel at once, wipes the command byte and asks the neighbouring status register to clear.

Top module: `out_gate_ctrl`

## Requirements
- R1: On a rising clock edge with `cmd_load_i` high and `uvlo_i` low, the command latch takes `cmd_i`. Without the strobe, changes on `cmd_i` have no effect on `gate_o`.
- R2: The direct inputs are ORed into the gate term. `pwm_i[0]` drives channel index 4, `pwm_i[1]` drives channel index 5, and no other channel responds to them.
- R3: While `en_i` is low, `gate_o` is all zero. When `en_i` returns high, the channels that were commanded on turn on again in the same cycle, with no new load.
- R4: `ovp_i` takes effect two clock edges after it is sampled high. It then forces all of `gate_o` to zero. Two edges after it is sampled low again, the commanded state returns.
- R5: `otemp_i[k]`, after the same two-edge delay, forces only `gate_o[k]` to zero. Channel k turns on again two edges after the flag is sampled low, provided its command or direct input is still high.
- R6: While `uvlo_i` is high, `gate_o` is zero without delay and `status_clr_o` is high. Each edge with `uvlo_i` high clears the command latch, so channels stay off after recovery until a new load arrives.
- R7: After reset, the command latch and both synchronizers are zero. With the direct inputs low, `gate_o` is therefore zero.
- R8: When `cmd_load_i` and `uvlo_i` are both high at the same edge, the clear wins and the load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Command byte from the serial shift register; bit k = 1 turns channel k on |
| cmd_load_i | input | 1 | Strobe that loads `cmd_i` into the latch |
| pwm_i | input | 2 | Direct inputs for channel indices 4 and 5 |
| en_i | input | 1 | Global enable, active high |
| ovp_i | input | 1 | Supply overvoltage flag (asynchronous) |
| uvlo_i | input | 1 | Logic undervoltage flag (synchronous to the clock) |
| otemp_i | input | 8 | Overtemperature flag for each channel (asynchronous) |
| gate_o | output | 8 | Gate enable for each channel |
| status_clr_o | output | 1 | Clear request to the fault status register |

## Verification
The hardest situation to reach from the ports is the exact cycle in which a synchronized flag takes effect or releases. The difference between one and two edges is only visible if the bench samples between the edges. The bench therefore changes `ovp_i` or `otemp_i` just after a falling edge. It checks `gate_o` after the first rising edge, when the old value must still show, and again after the second, when the new value must show. It also checks that the command byte survives the overvoltage and enable gating and reappears. For the undervoltage case, it raises `uvlo_i` in the same cycle as a load strobe, to show that the clear wins over the load.

// File: rtl/out_gate_pkg.sv
package out_gate_pkg;
  localparam int unsigned N_OUT_DEF   = 8;
  localparam int unsigned N_PWM_DEF   = 2;
  localparam int unsigned PWM_BASE_DEF = 4;
  localparam int unsigned SYNC_DEF    = 2;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmd_latch.sv
module cmd_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cmd_i,
  input  logic             load_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (clr_i)  cmd_o <= '0;   // clear beats load
    else if (load_i) cmd_o <= cmd_i;
  end
endmodule

// File: rtl/gate_combine.sv
module gate_combine #(
  parameter int unsigned N_OUT    = 8,
  parameter int unsigned N_PWM    = 2,
  parameter int unsigned PWM_BASE = 4
) (
  input  logic [N_OUT-1:0] cmd_i,
  input  logic [N_PWM-1:0] pwm_i,
  input  logic             en_i,
  input  logic             ov_i,
  input  logic             uv_i,
  input  logic [N_OUT-1:0] ot_i,
  output logic [N_OUT-1:0] gate_o
);
  localparam int unsigned PWM_TOP = PWM_BASE + N_PWM;

  logic glb_ok;
  assign glb_ok = en_i & ~ov_i & ~uv_i;

  for (genvar k = 0; k < N_OUT; k++) begin : g_ch
    logic req;
    if (k >= PWM_BASE && k < PWM_TOP) begin : g_pwm
      assign req = cmd_i[k] | pwm_i[k-PWM_BASE];
    end else begin : g_cmd
      assign req = cmd_i[k];
    end
    assign gate_o[k] = req & glb_ok & ~ot_i[k];
  end
endmodule

// File: rtl/out_gate_ctrl.sv
module out_gate_ctrl
  import out_gate_pkg::*;
#(
  parameter int unsigned N_OUT    = N_OUT_DEF,
  parameter int unsigned N_PWM    = N_PWM_DEF,
  parameter int unsigned PWM_BASE = PWM_BASE_DEF,
  parameter int unsigned SYNC     = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] cmd_i,
  input  logic             cmd_load_i,
  input  logic [N_PWM-1:0] pwm_i,
  input  logic             en_i,
  input  logic             ovp_i,
  input  logic             uvlo_i,
  input  logic [N_OUT-1:0] otemp_i,
  output logic [N_OUT-1:0] gate_o,
  output logic             status_clr_o
);
  localparam int unsigned FLAG_W = N_OUT + 1;

  logic [N_OUT-1:0]  cmd_q;
  logic [FLAG_W-1:0] flag_s;

  cmd_latch #(.WIDTH(N_OUT)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .load_i (cmd_load_i),
    .clr_i  (uvlo_i),
    .cmd_o  (cmd_q)
  );

  flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ovp_i, otemp_i}),
    .q_o    (flag_s)
  );

  gate_combine #(.N_OUT(N_OUT), .N_PWM(N_PWM), .PWM_BASE(PWM_BASE)) u_comb (
    .cmd_i  (cmd_q),
    .pwm_i  (pwm_i),
    .en_i   (en_i),
    .ov_i   (flag_s[N_OUT]),
    .uv_i   (uvlo_i),
    .ot_i   (flag_s[N_OUT-1:0]),
    .gate_o (gate_o)
  );

  assign status_clr_o = uvlo_i;
endmodule

// File: rtl/out_gate_ctrl_chk.sv
module out_gate_ctrl_chk #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_PWM = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_load_i,
  input logic [N_PWM-1:0] pwm_i,
  input logic             en_i,
  input logic             ovp_i,
  input logic             uvlo_i,
  input logic [N_OUT-1:0] otemp_i,
  input logic [N_OUT-1:0] gate_o,
  input logic             status_clr_o
);
  p_en_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> gate_o == '0);

  p_ovp_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovp_i, 2) |-> gate_o == '0);

  p_uv_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> (gate_o == '0 && status_clr_o));

  p_uv_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(uvlo_i) && pwm_i == '0) |-> gate_o == '0);

  for (genvar k = 0; k < N_OUT; k++) begin : g_ot
    p_ot_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(otemp_i[k], 2) |-> !gate_o[k]);
  end
endmodule

bind out_gate_ctrl out_gate_ctrl_chk #(.N_OUT(N_OUT), .N_PWM(N_PWM)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_load_i   (cmd_load_i),
  .pwm_i        (pwm_i),
  .en_i         (en_i),
  .ovp_i        (ovp_i),
  .uvlo_i       (uvlo_i),
  .otemp_i      (otemp_i),
  .gate_o       (gate_o),
  .status_clr_o (status_clr_o)
);

// File: tb/sim_out_gate_ctrl.sv
`timescale 1ns/1ps
module sim_out_gate_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd = '0;
  logic       load = 1'b0;
  logic [1:0] pwm = '0;
  logic       en = 1'b1;
  logic       ovp = 1'b0;
  logic       uvlo = 1'b0;
  logic [7:0] ot = '0;
  logic [7:0] gate;
  logic       sclr;
  int errs = 0;
  int chks = 0;

  always #4 clk = ~clk;

  out_gate_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_load_i(load), .pwm_i(pwm),
    .en_i(en), .ovp_i(ovp), .uvlo_i(uvlo), .otemp_i(ot), .gate_o(gate),
    .status_clr_o(sclr)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_cmd(input logic [7:0] v);
    cmd = v; load = 1'b1;
    tick(1);
    load = 1'b0;
  endtask

  task automatic t_reset;  // R7
    chk("R7 reset gate", {1'b0, gate}, 9'h000);
    chk("R7 reset clr", {8'h0, sclr}, 9'h000);
  endtask

  task automatic t_load;  // R1
    load_cmd(8'hA5);
    chk("R1 load", {1'b0, gate}, 9'h0A5);
    cmd = 8'h3C; tick(2);
    chk("R1 no strobe", {1'b0, gate}, 9'h0A5);
  endtask

  task automatic t_pwm;  // R2
    load_cmd(8'h00);
    pwm = 2'b01; #1;
    chk("R2 pwm0 ch4", {1'b0, gate}, 9'h010);
    pwm = 2'b10; #1;
    chk("R2 pwm1 ch5", {1'b0, gate}, 9'h020);
    load_cmd(8'h10); pwm = 2'b01; #1;
    chk("R2 or both", {1'b0, gate}, 9'h010);
    pwm = 2'b00; #1;
    chk("R2 cmd only", {1'b0, gate}, 9'h010);
  endtask

  task automatic t_en;  // R3
    load_cmd(8'h81);
    en = 1'b0; #1;
    chk("R3 en low", {1'b0, gate}, 9'h000);
    tick(3);
    en = 1'b1; #1;
    chk("R3 restore", {1'b0, gate}, 9'h081);
  endtask

  task automatic t_ovp;  // R4
    load_cmd(8'h5A);
    ovp = 1'b1; tick(1);
    chk("R4 one edge", {1'b0, gate}, 9'h05A);
    tick(1);
    chk("R4 two edges", {1'b0, gate}, 9'h000);
    ovp = 1'b0; tick(1);
    chk("R4 still off", {1'b0, gate}, 9'h000);
    tick(1);
    chk("R4 recover", {1'b0, gate}, 9'h05A);
  endtask

  task automatic t_ot;  // R5
    load_cmd(8'hFF);
    ot = 8'h08; tick(1);
    chk("R5 one edge", {1'b0, gate}, 9'h0FF);
    tick(1);
    chk("R5 own only", {1'b0, gate}, 9'h0F7);
    ot = 8'h00; tick(2);
    chk("R5 auto retry", {1'b0, gate}, 9'h0FF);
    load_cmd(8'h00); ot = 8'h08; tick(2); ot = 8'h00; tick(2);
    chk("R5 cmd off stays", {1'b0, gate}, 9'h000);
  endtask

  task automatic t_uv;  // R6, R8
    load_cmd(8'hC3);
    uvlo = 1'b1; #1;
    chk("R6 immediate off", {sclr, gate}, 9'h100);
    cmd = 8'h0F; load = 1'b1; tick(1);
    load = 1'b0; uvlo = 1'b0; #1;
    chk("R8 clear beats load", {sclr, gate}, 9'h000);
    tick(2);
    chk("R6 stays off", {sclr, gate}, 9'h000);
    load_cmd(8'h24);
    chk("R6 new load", {sclr, gate}, 9'h024);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_load();
    t_pwm();
    t_en();
    t_ovp();
    t_ot();
    t_uv();
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    #100000;
    errs++; chks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule